// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches 24 input pins split into three groups of eight and raises one interrupt request per group when any selected pin in that group changes level. Each pin has its own select bit in its group's mask register; a change in either direction on a selected pin sets the group's single pending flag. Nothing in the block chooses between edge polarities. Only a change of level is detected.

A request leaves the block only when the group's flag is set, the group is switched on in the control register, and the global interrupt enable input is high. Software reaches the control, flag and mask registers over a simple byte-wide register bus. A pending flag clears when software writes a one to its bit or when the interrupt consumer pulses the group's acknowledge. The three requests are also reduced to a fixed-priority index, with group 0 highest, for the consumer to use.

Pins are asynchronous. Each one passes through two synchronizing flops and is then compared with the previous synchronized sample. The first sample taken after reset only primes the comparison, so the pin levels present when reset is released never count as a change.

Top module: `grp_chg_irq`

## Requirements
- R1: Pin number g*8+b belongs to group g (g = 0..2, b = 0..7). Its select bit is bit b of the mask register at address 0x6B+g, so the addresses are 0x6B, 0x6C and 0x6D.
- R2: The control register at address 0x68 holds the group enables in bits 2:0, with bit g for group g. Bits 7:3 always read as zero, and writes to them have no effect.
- R3: The flag register at address 0x3B holds the pending flags in bits 2:0, with bit g for group g. Bits 7:3 always read as zero. Reads of any other address return zero.
- R4: A level change in either direction on a selected pin sets its group's flag. The flag reads as set after the third rising clock edge that follows the change, and not after the second.
- R5: A change on a pin whose select bit is clear never sets a flag. Setting that select bit afterwards does not set the flag for the earlier change.
- R6: irq_o[g] is high exactly when flag g, enable bit g and gie_i are all high.
- R7: Writing a one to bit g of the flag register clears flag g. Writing a zero to that bit leaves flag g unchanged.
- R8: A one-cycle pulse on ack_i[g] clears flag g.
- R9: When a set event and a clear (write-one or acknowledge) reach a group in the same cycle, the flag ends up set.
- R10: After reset every register reads zero and no request is asserted. The pin levels present when reset is released are not treated as a change.
- R11: When any request is high, irq_any_o is high and irq_idx_o gives the lowest-numbered group whose request is high. When no request is high, irq_any_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 24 | Monitored pins; group g uses bits 8g+7:8g |
| gie_i | input | 1 | Global interrupt enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i (combinational) |
| ack_i | input | 3 | Per-group acknowledge; clears that group's flag |
| irq_o | output | 3 | Per-group interrupt requests |
| irq_any_o | output | 1 | High when any request is high |
| irq_idx_o | output | 2 | Lowest-numbered active group |

## Verification
The bench builds the block with its default parameters: three groups of eight pins, two synchronizer stages and the default register addresses. With these values every group boundary and every mask register can be reached from the vector table. Two synchronizer stages make the change-to-flag latency a fixed three edges. The bench depends on that fixed latency to place a clear in exactly the cycle in which a set event arrives, and to show that the flag is still clear one edge before that cycle.

// File: rtl/grp_chg_pkg.sv
package grp_chg_pkg;
  localparam int unsigned DEF_N_GRP     = 3;
  localparam int unsigned DEF_DATA_W    = 8;
  localparam int unsigned DEF_ADDR_W    = 8;
  localparam int unsigned DEF_SYNC      = 2;
  localparam logic [7:0]  DEF_CTRL_ADDR = 8'h68;
  localparam logic [7:0]  DEF_FLAG_ADDR = 8'h3B;
  localparam logic [7:0]  DEF_MASK_BASE = 8'h6B;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/chg_sync_detect.sv
module chg_sync_detect #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0]      sync_q [STAGES];
  logic [STAGES-1:0] vld_q;
  logic [W-1:0]      prev_q;
  logic              prev_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
      vld_q      <= '0;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else begin
      sync_q[0] <= pin_i;
      vld_q[0]  <= 1'b1;
      for (int s = 1; s < STAGES; s++) begin
        sync_q[s] <= sync_q[s-1];
        vld_q[s]  <= vld_q[s-1];
      end
      prev_q     <= sync_q[STAGES-1];
      prev_vld_q <= vld_q[STAGES-1];
    end
  end

  // first valid sample only primes prev_q
  assign chg_o = (sync_q[STAGES-1] ^ prev_q) & {W{prev_vld_q}};
endmodule

// File: rtl/chg_group_flag.sv
module chg_group_flag #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] chg_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         gie_i,
  output logic         set_o,
  output logic         flag_o,
  output logic         req_o
);
  logic flag_q;

  assign set_o = |(chg_i & mask_i);

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_o | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
  assign req_o  = flag_q & en_i & gie_i;
endmodule

// File: rtl/chg_regs.sv
module chg_regs #(
  parameter int unsigned  N_GRP     = 3,
  parameter int unsigned  ADDR_W    = 8,
  parameter int unsigned  DATA_W    = 8,
  parameter logic [7:0]   CTRL_ADDR = 8'h68,
  parameter logic [7:0]   FLAG_ADDR = 8'h3B,
  parameter logic [7:0]   MASK_BASE = 8'h6B
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [N_GRP-1:0]        flag_i,
  output logic [N_GRP-1:0]        en_o,
  output logic [N_GRP*DATA_W-1:0] mask_o,
  output logic [N_GRP-1:0]        wclr_o,
  output logic [DATA_W-1:0]       rdata_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

  logic [N_GRP-1:0] en_q;
  logic [DATA_W-1:0] mask_q [N_GRP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       en_q <= '0;
    else if (we_i && addr_i == CTRL_A) en_q <= wdata_i[N_GRP-1:0];
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_mask
    localparam logic [ADDR_W-1:0] MA = ADDR_W'(MASK_BASE) + ADDR_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   mask_q[g] <= '0;
      else if (we_i && addr_i == MA) mask_q[g] <= wdata_i;
    end
    assign mask_o[g*DATA_W +: DATA_W] = mask_q[g];
  end

  assign en_o   = en_q;
  assign wclr_o = (we_i && addr_i == FLAG_A) ? wdata_i[N_GRP-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_A) rdata_o[N_GRP-1:0] = en_q;
    if (addr_i == FLAG_A) rdata_o[N_GRP-1:0] = flag_i;
    for (int g = 0; g < N_GRP; g++)
      if (addr_i == ADDR_W'(MASK_BASE) + ADDR_W'(g)) rdata_o = mask_q[g];
  end
endmodule

// File: rtl/grp_chg_irq.sv
module grp_chg_irq
  import grp_chg_pkg::*;
#(
  parameter int unsigned N_GRP     = DEF_N_GRP,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned SYNC      = DEF_SYNC,
  parameter logic [7:0]  CTRL_ADDR = DEF_CTRL_ADDR,
  parameter logic [7:0]  FLAG_ADDR = DEF_FLAG_ADDR,
  parameter logic [7:0]  MASK_BASE = DEF_MASK_BASE,
  localparam int unsigned N_PIN    = N_GRP * DATA_W,
  localparam int unsigned IDX_W    = idx_width(N_GRP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PIN-1:0]  pin_i,
  input  logic              gie_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_GRP-1:0]  ack_i,
  output logic [N_GRP-1:0]  irq_o,
  output logic              irq_any_o,
  output logic [IDX_W-1:0]  irq_idx_o
);
  logic [N_GRP-1:0] en, wclr, flag_q, grp_set;
  logic [N_PIN-1:0] mask;

  chg_regs #(
    .N_GRP(N_GRP), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .FLAG_ADDR(FLAG_ADDR), .MASK_BASE(MASK_BASE)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .flag_i(flag_q), .en_o(en), .mask_o(mask),
    .wclr_o(wclr), .rdata_o(rdata_o)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [DATA_W-1:0] chg;

    chg_sync_detect #(.W(DATA_W), .STAGES(SYNC)) u_det (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .pin_i(pin_i[g*DATA_W +: DATA_W]), .chg_o(chg)
    );

    chg_group_flag #(.W(DATA_W)) u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni), .chg_i(chg),
      .mask_i(mask[g*DATA_W +: DATA_W]),
      .clr_i(wclr[g] | ack_i[g]), .en_i(en[g]), .gie_i(gie_i),
      .set_o(grp_set[g]), .flag_o(flag_q[g]), .req_o(irq_o[g])
    );
  end

  // fixed priority, group 0 highest
  always_comb begin
    irq_idx_o = '0;
    for (int g = N_GRP - 1; g >= 0; g--)
      if (irq_o[g]) irq_idx_o = IDX_W'(g);
  end
  assign irq_any_o = |irq_o;
endmodule

// File: rtl/grp_chg_irq_chk.sv
module grp_chg_irq_chk #(
  parameter int unsigned N_GRP     = 3,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IDX_W     = 2,
  parameter logic [7:0]  CTRL_ADDR = 8'h68,
  parameter logic [7:0]  FLAG_ADDR = 8'h3B
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gie_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_GRP-1:0]  ack_i,
  input logic [N_GRP-1:0]  irq_o,
  input logic              irq_any_o,
  input logic [IDX_W-1:0]  irq_idx_o,
  input logic [N_GRP-1:0]  flag_q,
  input logic [N_GRP-1:0]  grp_set
);
  a_r2_ctrl_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(CTRL_ADDR) |-> rdata_o[DATA_W-1:N_GRP] == '0);

  a_r3_flag_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(FLAG_ADDR) |-> rdata_o[DATA_W-1:N_GRP] == '0);

  a_r11_idx_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_any_o |-> irq_o[irq_idx_o]);

  for (genvar g = 0; g < N_GRP; g++) begin : g_chk
    a_r6_gie_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gie_i |-> !irq_o[g]);

    a_r4_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flag_q[g] && !grp_set[g] |=> !flag_q[g]);

    a_r7_wr1_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && addr_i == ADDR_W'(FLAG_ADDR) && wdata_i[g] && !grp_set[g] |=> !flag_q[g]);

    a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_i[g] && !grp_set[g] |=> !flag_q[g]);

    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_set[g] |=> flag_q[g]);
  end
endmodule

bind grp_chg_irq grp_chg_irq_chk #(
  .N_GRP(N_GRP), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
  .CTRL_ADDR(CTRL_ADDR), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gie_i(gie_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_i(ack_i),
  .irq_o(irq_o), .irq_any_o(irq_any_o), .irq_idx_o(irq_idx_o),
  .flag_q(flag_q), .grp_set(grp_set)
);

// File: tb/grp_chg_irq_test.sv
module grp_chg_irq_test;
  localparam logic [7:0] A_CTRL = 8'h68;
  localparam logic [7:0] A_FLAG = 8'h3B;
  localparam logic [7:0] A_MSK0 = 8'h6B;

  typedef struct packed {
    logic [23:0] tog;
    logic [23:0] msk;
    logic [2:0]  exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{24'h000001, 24'hFFFFFF, 3'b001},
    '{24'h000001, 24'hFFFFFF, 3'b001},
    '{24'h000200, 24'h000200, 3'b010},
    '{24'h100000, 24'h080000, 3'b000},
    '{24'h801008, 24'h801008, 3'b111},
    '{24'h000080, 24'h000000, 3'b000},
    '{24'h010000, 24'hFFFFFF, 3'b100},
    '{24'h00FF00, 24'h000100, 3'b010},
    '{24'h000000, 24'hFFFFFF, 3'b000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] pin_i = 24'hA5C35A;
  logic        gie_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [2:0]  ack_i = '0;
  logic [2:0]  irq_o;
  logic        irq_any_o;
  logic [1:0]  irq_idx_o;

  int total = 0;
  int bad = 0;
  logic [7:0] rv;

  always #10 clk_i = ~clk_i;

  grp_chg_irq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .gie_i(gie_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ack_i(ack_i), .irq_o(irq_o), .irq_any_o(irq_any_o), .irq_idx_o(irq_idx_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr_i = a;
    #2 d = rdata_o;
  endtask

  task automatic masks(input logic [23:0] m);
    for (int g = 0; g < 3; g++) wr(A_MSK0 + 8'(g), m[g*8 +: 8]);
  endtask

  task automatic toggle(input logic [23:0] t);
    @(negedge clk_i);
    pin_i = pin_i ^ t;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R10: reset state, pin levels at release are no change
    rd(A_CTRL, rv); chk("R10 ctrl", rv, 0);
    for (int g = 0; g < 3; g++) begin
      rd(A_MSK0 + 8'(g), rv); chk("R10 mask", rv, 0);
    end
    chk("R10 irq", {irq_any_o, irq_o}, 0);
    masks(24'hFFFFFF);
    repeat (4) @(negedge clk_i);
    rd(A_FLAG, rv); chk("R10 flag", rv, 0);

    // R1 R4 R5: vector table
    for (int i = 0; i < NV; i++) begin
      masks(VECS[i].msk);
      wr(A_FLAG, 8'h07);
      toggle(VECS[i].tog);
      rd(A_FLAG, rv); chk("R1/R4 vec", rv, {5'b0, VECS[i].exp});
    end

    // R1: mask registers read back per group
    masks(24'h3C5AA5);
    rd(A_MSK0, rv);        chk("R1 mask0", rv, 8'hA5);
    rd(A_MSK0 + 8'd2, rv); chk("R1 mask2", rv, 8'h3C);

    // R2 R3: read-only high bits, unused address
    wr(A_CTRL, 8'hFF); rd(A_CTRL, rv); chk("R2 ctrl hi", rv, 8'h07);
    wr(A_FLAG, 8'hFF); rd(A_FLAG, rv); chk("R3 flag hi", rv, 8'h00);
    rd(8'h6E, rv); chk("R3 unused", rv, 0);

    // R4: latency, not set after two edges
    masks(24'hFFFFFF); wr(A_FLAG, 8'h07);
    @(negedge clk_i); pin_i = pin_i ^ 24'h000004;
    repeat (2) @(negedge clk_i);
    rd(A_FLAG, rv); chk("R4 early", rv, 0);
    @(negedge clk_i);
    rd(A_FLAG, rv); chk("R4 third edge", rv, 8'h01);

    // R5: no retroactive set
    masks(24'h000000); wr(A_FLAG, 8'h07);
    toggle(24'h000002);
    masks(24'hFFFFFF);
    repeat (4) @(negedge clk_i);
    rd(A_FLAG, rv); chk("R5 retro", rv, 0);

    // R6: gating
    wr(A_FLAG, 8'h07); toggle(24'h000100);
    wr(A_CTRL, 8'h02); gie_i = 1'b0; #2;
    chk("R6 gie off", irq_o, 3'b000);
    gie_i = 1'b1; #2;
    chk("R6 all on", irq_o, 3'b010);
    wr(A_CTRL, 8'h05); #2;
    chk("R6 en off", irq_o, 3'b000);

    // R7: write zero no effect, write one clears
    wr(A_FLAG, 8'h00); rd(A_FLAG, rv); chk("R7 wr0", rv, 8'h02);
    wr(A_FLAG, 8'h02); rd(A_FLAG, rv); chk("R7 wr1", rv, 8'h00);

    // R8: acknowledge clears
    toggle(24'h020000);
    @(negedge clk_i); ack_i = 3'b100;
    @(negedge clk_i); ack_i = 3'b000;
    rd(A_FLAG, rv); chk("R8 ack", rv, 0);

    // R9: set wins over ack in same cycle
    @(negedge clk_i); pin_i = pin_i ^ 24'h000001;
    @(negedge clk_i);
    @(negedge clk_i); ack_i = 3'b001;
    @(negedge clk_i); ack_i = 3'b000;
    rd(A_FLAG, rv); chk("R9 ack vs set", rv, 8'h01);
    wr(A_FLAG, 8'h07);
    // R9: set wins over write-one
    @(negedge clk_i); pin_i = pin_i ^ 24'h000800;
    @(negedge clk_i);
    @(negedge clk_i); addr_i = A_FLAG; wdata_i = 8'h02; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
    rd(A_FLAG, rv); chk("R9 wr1 vs set", rv, 8'h02);

    // R11: priority index
    wr(A_FLAG, 8'h07); wr(A_CTRL, 8'h07); gie_i = 1'b1;
    #2 chk("R11 none", irq_any_o, 0);
    toggle(24'h010100);
    #2 chk("R11 idx1", {irq_any_o, irq_idx_o}, 3'b101);
    toggle(24'h000001);
    #2 chk("R11 idx0", {irq_any_o, irq_idx_o}, 3'b100);
    wr(A_FLAG, 8'h03);
    #2 chk("R11 idx2", {irq_any_o, irq_idx_o}, 3'b110);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule